// File: doc/BRIEF.md
# Lamp Inrush Threshold Profile Sequencer

This block produces a time-staged overcurrent threshold code for one lamp-driving output channel. When the channel's output-enable rises, the code starts at a high inrush level. It then steps down through two high levels and four descending intermediate levels, then holds at a steady-state level. A configuration byte sets the steady-state level, the speed of the stepping, whether the first stage uses the higher of the two high levels, and whether bulb-cooling management is active. The same byte also sets the speed at which a warm bulb cools.

Stage boundaries are counted in prescaled ticks. One speed unit lasts `preIn + 1` clock cycles. A tick lasts 1, 2, 4 or 8 units, depending on the selected speed. Each stage lasts `STAGE_TICKS` ticks.

When cooling management is on and the output turns off, the stage reached so far is kept. It then falls by one for every cooling interval that passes. On the next turn-on, the profile re-enters at that remembered stage, so a bulb that is still warm gets a shorter inrush allowance. The configuration byte and the prescaler value are captured only while the output is off, so a running profile is never altered.

Top module: `inrush_profile_seq`

## Requirements
- R1: After synchronous reset, `levelCode` is 7 (idle), `stageIdx` is 0 and `steadyLvl` is 1 (level LO2). All configuration fields hold the value 0.
- R2: On the first clock edge where `outEn` is sampled high while the sequencer is idle, with cooling mode off, the sequencer enters stage 0. With `cfgIn[7]`=0, stage 0 shows `levelCode` 0 (HI1).
- R3: When `cfgIn[7]`=1, stage 0 shows `levelCode` 1 (HI2) instead of 0. Stage 1 shows code 1 in both cases.
- R4: Each stage lasts `STAGE_TICKS` ticks, and the stage then advances by one. Stages 2 to 5 show codes 2 to 5 (OC1 to OC4). Stage 6 shows code 6 (steady level) and holds while the output stays on. `stageIdx` equals the stage number.
- R5: The inrush tick length is selected by `cfgIn[3:2]`: 00 gives 4 units (slow), 01 gives 1 unit (fast), 10 gives 2 units (medium) and 11 gives 8 units (very slow). A unit is `preIn + 1` clock cycles, and the tick counter restarts on every on/off transition.
- R6: `steadyLvl` reports the steady-state level selected by `cfgIn[1:0]`: 00 gives 1 (LO2), 01 gives 2 (LO3), 10 gives 3 (LO4) and 11 gives 0 (LO1).
- R7: With `cfgIn[6]`=1, turning off stores the stage reached. Each cooling interval of `STAGE_TICKS` cooling ticks lowers the stored stage by one, down to a floor of 0. The next turn-on enters the stored stage.
- R8: The cooling tick length is selected by `cfgIn[5:4]`: 00 gives 2 units, 01 gives 4 units, 10 gives 1 unit and 11 gives 2 units.
- R9: With `cfgIn[6]`=0, every turn-on enters stage 0, whatever the previous off time.
- R10: While the output is on, changes on `cfgIn` and `preIn` have no effect on any output. While the output is off, `levelCode` is 7 and `stageIdx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| outEn | input | 1 | Output-enable of the channel |
| cfgIn | input | 8 | Configuration byte: [7] high select, [6] cooling mode, [5:4] cooling speed, [3:2] inrush speed, [1:0] steady level |
| preIn | input | PRE_W | Prescaler: one speed unit is preIn+1 clock cycles |
| levelCode | output | 3 | Threshold code: 0 HI1, 1 HI2, 2-5 OC1-OC4, 6 steady, 7 idle |
| stageIdx | output | 3 | Current stage number, 0 while idle |
| steadyLvl | output | 2 | Applicable steady level: 0 LO1, 1 LO2, 2 LO3, 3 LO4 |

## Verification
The assertions assume that `cfgIn` and `preIn` stay constant while the output is off. They may change only in the same cycle in which `outEn` falls, or while it is high. Under that assumption, the captured configuration during a cooling interval is the one that times it.

The stimulus follows this rule. A new configuration is applied together with the falling edge of `outEn`. Values that change while the output is on are restored before the next off period begins.

Under this discipline, a behavioural reference model is enough to predict every output. It tracks only elapsed on-time and off-time in clock cycles and the stage stored at turn-off.

// File: rtl/inrush_pkg.sv
package inrush_pkg;

  typedef struct packed {
    logic       hiSel;
    logic       coolMode;
    logic [1:0] coolSpd;
    logic [1:0] inSpd;
    logic [1:0] steadySel;
  } prof_cfg_t;

  typedef struct packed {
    logic loadCfg;
    logic clearPre;
    logic useCool;
  } seq_strobe_t;

  localparam logic [2:0] LAST_STAGE = 3'd6;
  localparam logic [2:0] IDLE_CODE  = 3'd7;

  // log2 of units per inrush tick: slow 4, fast 1, medium 2, very slow 8
  function automatic logic [1:0] inrushShift(input logic [1:0] code);
    case (code)
      2'b00:   return 2'd2;
      2'b01:   return 2'd0;
      2'b10:   return 2'd1;
      default: return 2'd3;
    endcase
  endfunction

  // log2 of units per cooling tick: medium 2, slow 4, fast 1, medium 2
  function automatic logic [1:0] coolShift(input logic [1:0] code);
    case (code)
      2'b00:   return 2'd1;
      2'b01:   return 2'd2;
      2'b10:   return 2'd0;
      default: return 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/inrush_datapath.sv
module inrush_datapath
  import inrush_pkg::*;
#(
  parameter int PRE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_strobe_t       stb,
  input  logic [7:0]        cfgIn,
  input  logic [PRE_W-1:0]  preIn,
  input  logic              active,
  input  logic [2:0]        stage,
  output logic              tick,
  output logic              coolMode,
  output logic [2:0]        levelCode,
  output logic [2:0]        stageIdx,
  output logic [1:0]        steadyLvl
);

  localparam int PW = PRE_W + 4;

  prof_cfg_t        cfgReg;
  logic [PRE_W-1:0] preReg;
  logic [PW-1:0]    preCnt;
  logic [PW-1:0]    unitLen;
  logic [PW-1:0]    period;
  logic [1:0]       shiftSel;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgReg <= '0;
      preReg <= '0;
    end else if (stb.loadCfg) begin
      cfgReg <= prof_cfg_t'(cfgIn);
      preReg <= preIn;
    end
  end

  always_comb begin
    shiftSel = stb.useCool ? coolShift(cfgReg.coolSpd) : inrushShift(cfgReg.inSpd);
    unitLen  = {{(PW-PRE_W){1'b0}}, preReg} + PW'(1);
    period   = unitLen << shiftSel;
    tick     = !stb.clearPre && (preCnt == period - PW'(1));
  end

  always_ff @(posedge clk) begin
    if (rst || stb.clearPre || tick) preCnt <= '0;
    else                             preCnt <= preCnt + PW'(1);
  end

  always_comb begin
    coolMode = cfgReg.coolMode;
    stageIdx = active ? stage : 3'd0;
    if (!active)          levelCode = IDLE_CODE;
    else if (stage == '0) levelCode = cfgReg.hiSel ? 3'd1 : 3'd0;
    else                  levelCode = stage;
    case (cfgReg.steadySel)
      2'b00:   steadyLvl = 2'd1;
      2'b01:   steadyLvl = 2'd2;
      2'b10:   steadyLvl = 2'd3;
      default: steadyLvl = 2'd0;
    endcase
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !stb.loadCfg |=> $stable(cfgReg)); // R10
  AST_PRE_RESTART: assert property (@(posedge clk) disable iff (rst)
    stb.clearPre |=> (preCnt == '0)); // R5

endmodule

// File: rtl/inrush_control.sv
module inrush_control
  import inrush_pkg::*;
#(
  parameter int STAGE_TICKS = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        outEn,
  input  logic        tick,
  input  logic        coolMode,
  output seq_strobe_t stb,
  output logic        active,
  output logic [2:0]  stage
);

  localparam int TW = (STAGE_TICKS > 1) ? $clog2(STAGE_TICKS) : 1;
  localparam logic [TW-1:0] TLAST = TW'(STAGE_TICKS - 1);

  logic [TW-1:0] tickCnt;
  logic [2:0]    coolStage;

  always_comb begin
    stb.loadCfg  = !outEn;
    stb.clearPre = (outEn != active);
    stb.useCool  = !active;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      stage     <= '0;
      coolStage <= '0;
      tickCnt   <= '0;
    end else if (outEn && !active) begin
      active  <= 1'b1;
      stage   <= coolMode ? coolStage : 3'd0;
      tickCnt <= '0;
    end else if (!outEn && active) begin
      active    <= 1'b0;
      coolStage <= stage;
      tickCnt   <= '0;
    end else if (tick) begin
      if (tickCnt == TLAST) begin
        tickCnt <= '0;
        if (active && stage != LAST_STAGE) stage <= stage + 3'd1;
        if (!active && coolStage != '0)    coolStage <= coolStage - 3'd1;
      end else begin
        tickCnt <= tickCnt + TW'(1);
      end
    end
  end

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (outEn && active && !tick) |=> $stable(stage)); // R4
  AST_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
    (outEn && active) |=> (stage >= $past(stage))); // R4
  AST_COLD_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (outEn && !active && !coolMode) |=> (stage == 3'd0)); // R9
  AST_COOL_DECAY: assert property (@(posedge clk) disable iff (rst)
    (!outEn && !active) |=> (coolStage <= $past(coolStage))); // R7

endmodule

// File: rtl/inrush_profile_seq.sv
module inrush_profile_seq
  import inrush_pkg::*;
#(
  parameter int PRE_W       = 4,
  parameter int STAGE_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             outEn,
  input  logic [7:0]       cfgIn,
  input  logic [PRE_W-1:0] preIn,
  output logic [2:0]       levelCode,
  output logic [2:0]       stageIdx,
  output logic [1:0]       steadyLvl
);

  seq_strobe_t stb;
  logic        tick;
  logic        coolMode;
  logic        active;
  logic [2:0]  stage;

  inrush_control #(.STAGE_TICKS(STAGE_TICKS)) u_ctrl (
    .clk(clk), .rst(rst), .outEn(outEn), .tick(tick), .coolMode(coolMode),
    .stb(stb), .active(active), .stage(stage)
  );

  inrush_datapath #(.PRE_W(PRE_W)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .cfgIn(cfgIn), .preIn(preIn),
    .active(active), .stage(stage), .tick(tick), .coolMode(coolMode),
    .levelCode(levelCode), .stageIdx(stageIdx), .steadyLvl(steadyLvl)
  );

endmodule

// File: tb/sim_inrush_profile_seq.sv
`timescale 1ns/1ps
module sim_inrush_profile_seq;

  localparam int PRE_W = 4;
  localparam int ST    = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic outEn = 1'b0;
  logic [7:0] cfgIn = 8'h00;
  logic [PRE_W-1:0] preIn = '0;
  logic [2:0] levelCode, stageIdx;
  logic [1:0] steadyLvl;

  int vecs = 0;
  int fails = 0;
  bit done = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  inrush_profile_seq #(.PRE_W(PRE_W), .STAGE_TICKS(ST)) u0 (
    .clk(clk), .rst(rst), .outEn(outEn), .cfgIn(cfgIn), .preIn(preIn),
    .levelCode(levelCode), .stageIdx(stageIdx), .steadyLvl(steadyLvl)
  );

  // behavioural reference: elapsed on/off time in clocks
  bit   mActive = 0;
  int   mEntry = 0, mOnClk = 0, mOffStage = 0, mOffClk = 0;
  logic [7:0] mCfg = 8'h00;
  int   mPre = 0;

  function automatic int inUnits(input logic [1:0] c);
    case (c) 2'b00: return 4; 2'b01: return 1; 2'b10: return 2; default: return 8; endcase
  endfunction
  function automatic int coolUnits(input logic [1:0] c);
    case (c) 2'b00: return 2; 2'b01: return 4; 2'b10: return 1; default: return 2; endcase
  endfunction
  function automatic int curStage();
    int s = mEntry + mOnClk / (ST * inUnits(mCfg[3:2]) * (mPre + 1));
    return (s > 6) ? 6 : s;
  endfunction
  function automatic int coolNow();
    int s = mOffStage - mOffClk / (ST * coolUnits(mCfg[5:4]) * (mPre + 1));
    return (s < 0) ? 0 : s;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mActive = 0; mEntry = 0; mOnClk = 0; mOffStage = 0; mOffClk = 0;
      mCfg = 8'h00; mPre = 0;
    end else if (outEn) begin
      if (!mActive) begin
        mActive = 1; mOnClk = 0;
        mEntry = mCfg[6] ? coolNow() : 0;
      end else mOnClk++;
    end else begin
      mCfg = cfgIn; mPre = int'(preIn);
      if (mActive) begin
        mOffStage = curStage(); mActive = 0; mOffClk = 0;
      end else mOffClk++;
    end
  end

  task automatic check(input string t, input string what, input int got, input int exp);
    vecs++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", t, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      int s, expCode, expLvl;
      s = mActive ? curStage() : 0;
      if (!mActive)    expCode = 7;
      else if (s == 0) expCode = mCfg[7] ? 1 : 0;
      else             expCode = s;
      case (mCfg[1:0]) 2'b00: expLvl = 1; 2'b01: expLvl = 2; 2'b10: expLvl = 3; default: expLvl = 0; endcase
      check(tag, "levelCode", int'(levelCode), expCode);
      check(tag, "stageIdx", int'(stageIdx), s);
      check(tag, "steadyLvl", int'(steadyLvl), expLvl);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic runOn(input int n);
    outEn = 1'b1; cyc(n);
  endtask

  task automatic runOff(input logic [7:0] c, input logic [PRE_W-1:0] p, input int n);
    outEn = 1'b0; cfgIn = c; preIn = p; cyc(n);
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    tag = "R1";
    check(tag, "reset levelCode", int'(levelCode), 7);
    check(tag, "reset stageIdx", int'(stageIdx), 0);
    check(tag, "reset steadyLvl", int'(steadyLvl), 1);
    cyc(3);

    tag = "R2/R4/R5 slow";      runOn(80);
    tag = "R10 idle";           runOff(8'h87, 4'd1, 6);
    tag = "R3/R6/R5 fast";      runOn(40);
    tag = "R6";                 runOff(8'h09, 4'd2, 5);
    tag = "R5 medium";          runOn(90);
    tag = "R6";                 runOff(8'h0E, 4'd0, 5);
    tag = "R5 very slow";       runOn(110);

    tag = "R7";                 runOff(8'h44, 4'd0, 5);
    tag = "R7 first";           runOn(20);
    tag = "R7 short off";       runOff(8'h44, 4'd0, 5);
    tag = "R7 warm entry";      runOn(20);
    tag = "R7 long off";        runOff(8'h44, 4'd0, 40);
    tag = "R7 cold entry";      runOn(10);
    tag = "R7 brief off";       runOff(8'h44, 4'd0, 3);
    tag = "R7 re-entry";        runOn(15);

    tag = "R8 slow";            runOff(8'h54, 4'd0, 9);
    tag = "R8 slow entry";      runOn(20);
    tag = "R8 fast";            runOff(8'h64, 4'd0, 7);
    tag = "R8 fast entry";      runOn(20);
    tag = "R8 code11";          runOff(8'h74, 4'd1, 13);
    tag = "R8 code11 entry";    runOn(30);

    tag = "R9";                 runOff(8'h04, 4'd0, 3);
    tag = "R9 cold only";       runOn(20);

    tag = "R10 frozen";         runOff(8'h01, 4'd0, 4);
    runOn(5);
    cfgIn = 8'hFF; preIn = 4'd15;
    cyc(30);
    tag = "R10 idle";           runOff(8'h00, 4'd0, 6);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

endmodule